// File: doc/BRIEF.md
# Double-Buffered RGB Colour Matrix

This block remaps the gamut of a stream of RGB pixels. Each output channel is a weighted sum of the three input channels plus a signed offset, so each output row takes four 16-bit coefficients. The three rows give a 3x4 matrix of twelve coefficients. The sum is rounded and clamped into the unsigned pixel range. Pixels move through a fixed three-stage pipeline whether the matrix is applied or bypassed.

Two complete coefficient banks are held in the block, and a mode register picks bypass, bank A or bank B. The requested mode and the coefficient format do not take effect at once. Both are copied into active state on a frame-start pulse, and a read-only field reports the mode that is actually active. Host software fills the idle bank, writes the new mode, and the change happens cleanly at the next frame boundary, so no frame is ever processed with a half-written matrix.

Top module: `gamut_remap_db`

## Requirements
- R1: After reset the output valid is low, the requested mode is 0 and the active mode is 0, so the control word at address 0x00 reads 0.
- R2: With active mode 0 (bypass), every output pixel equals the input pixel.
- R3: The output valid and data follow the input valid exactly 3 clock edges later, in every mode. The output valid is still low 2 edges after the input.
- R4: With active mode 1 (bank A) or 2 (bank B), output row r equals round((c[r][0]*R + c[r][1]*G + c[r][2]*B) / 2^F) + c[r][3]. Coefficients are signed two's complement. The offset c[r][3] is a signed integer in pixel LSBs.
- R5: Format 0 treats the multiplying coefficients as S2.13 (F=13), and format 1 treats them as S3.12 (F=12). The format is written at address 0x01, bit 0, and it takes effect only at a frame-start pulse.
- R6: Control word address 0x00 holds the requested mode in bits [1:0] (read/write) and the active mode in bits [5:4] (read-only). The active mode and the active format change only on a cycle with frame_start_i high, and then take the requested values.
- R7: Mode 3 is reserved. When active it behaves exactly like bypass, and the active field reports 3.
- R8: Writes to the bank that is not active do not change the output. The new coefficients are used only after the mode selects that bank and a frame-start pulse occurs.
- R9: Results below 0 clamp to 0, and results above 2^PIX_W-1 clamp to 2^PIX_W-1.
- R10: Bank A words are at 0x08..0x0D and bank B words are at 0x10..0x15. Word k holds the coefficient with row-major index 2k in bits [15:0] and index 2k+1 in bits [31:16]. The index is row*4+column, with column 3 as the offset. The words read back as written.
- R11: Rounding is half-up: a result exactly halfway between two integers goes to the larger one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| frame_start_i | input | 1 | Frame boundary pulse; commits mode and format |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | PIX_W | Input red |
| pix_g_i | input | PIX_W | Input green |
| pix_b_i | input | PIX_W | Input blue |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_r_o | output | PIX_W | Output red |
| pix_g_o | output | PIX_W | Output green |
| pix_b_o | output | PIX_W | Output blue |

## Verification
The hardest situation to reach is a new mode, format or coefficient set that is pending but not yet committed. The stimulus writes the idle bank and the mode register while the other bank is active. It then sends pixels and reads the control word before any frame-start pulse, to show that both the output and the active field still reflect the old state. After the pulse it repeats the pixels. Format changes are staged the same way, so one pixel is checked under both interpretations of the same 16-bit coefficients.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int CW      = 16;
  localparam int NCOEF   = 12;
  localparam int NWORD   = NCOEF / 2;
  localparam int NROW    = 3;
  localparam int NCOL    = NCOEF / NROW;
  localparam int DW      = 32;
  localparam int AW      = 5;
  localparam int FRAC_F0 = 13;
  localparam int FRAC_F1 = 12;

  localparam logic [AW-1:0] ADDR_CTRL  = 5'h00;
  localparam logic [AW-1:0] ADDR_FMT   = 5'h01;
  localparam logic [AW-1:0] ADDR_BANKA = 5'h08;
  localparam logic [AW-1:0] ADDR_BANKB = 5'h10;

  typedef enum logic [1:0] {
    MODE_BYP = 2'd0,
    MODE_A   = 2'd1,
    MODE_B   = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;
endpackage

// File: rtl/cmx_regs.sv
module cmx_regs
  import cmx_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  input  logic                      frame_start_i,
  output mode_e                     mode_req_o,
  output mode_e                     act_mode_o,
  output logic                      act_fmt_o,
  output logic [NCOEF-1:0][CW-1:0]  coef_o
);
  logic [1:0][NCOEF-1:0][CW-1:0] bank_q;
  mode_e mode_q, act_q;
  logic  fmt_q, act_fmt_q;

  function automatic logic [AW-1:0] word_addr(input int b, input int w);
    return (b == 0 ? ADDR_BANKA : ADDR_BANKB) + AW'(w);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_BYP;
      fmt_q  <= 1'b0;
    end else if (we_i) begin
      if (addr_i == ADDR_CTRL) mode_q <= mode_e'(wdata_i[1:0]);
      if (addr_i == ADDR_FMT)  fmt_q  <= wdata_i[0];
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar w = 0; w < NWORD; w++) begin : g_word
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          bank_q[b][2*w]   <= '0;
          bank_q[b][2*w+1] <= '0;
        end else if (we_i && addr_i == word_addr(b, w)) begin
          bank_q[b][2*w]   <= wdata_i[CW-1:0];
          bank_q[b][2*w+1] <= wdata_i[2*CW-1:CW];
        end
      end
    end
  end

  // commit point: only a frame boundary changes what the datapath sees
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= MODE_BYP;
      act_fmt_q <= 1'b0;
    end else if (frame_start_i) begin
      act_q     <= mode_q;
      act_fmt_q <= fmt_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o[1:0] = mode_q;
      rdata_o[5:4] = act_q;
    end
    if (addr_i == ADDR_FMT) rdata_o[0] = fmt_q;
    for (int b = 0; b < 2; b++) begin
      for (int w = 0; w < NWORD; w++) begin
        if (addr_i == word_addr(b, w))
          rdata_o = {bank_q[b][2*w+1], bank_q[b][2*w]};
      end
    end
  end

  assign mode_req_o = mode_q;
  assign act_mode_o = act_q;
  assign act_fmt_o  = act_fmt_q;
  assign coef_o     = (act_q == MODE_B) ? bank_q[1] : bank_q[0];
endmodule

// File: rtl/cmx_row.sv
module cmx_row
  import cmx_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:0][PW-1:0]    pix_i,
  input  logic [PW-1:0]         byp_pix_i,
  input  logic [NCOL-1:0][CW-1:0] coef_i,
  input  logic                  fmt_i,
  input  logic                  byp_i,
  output logic [PW-1:0]         pix_o
);
  localparam int PRW = PW + 1 + CW;
  localparam int ACW = PRW + 2;
  localparam logic signed [ACW-1:0] MAXV = ACW'((1 << PW) - 1);
  localparam logic signed [ACW-1:0] HALF0 = ACW'(1) <<< (FRAC_F0 - 1);
  localparam logic signed [ACW-1:0] HALF1 = ACW'(1) <<< (FRAC_F1 - 1);

  logic signed [PRW-1:0] prod_q [3];
  logic signed [ACW-1:0] off_q, acc_q;
  logic                  byp1_q, byp2_q, fmt1_q, fmt2_q;
  logic [PW-1:0]         bpx1_q, bpx2_q;

  // stage 1: products and scaled offset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < 3; j++) prod_q[j] <= '0;
      off_q  <= '0;
      byp1_q <= 1'b1;
      fmt1_q <= 1'b0;
      bpx1_q <= '0;
    end else begin
      for (int j = 0; j < 3; j++)
        prod_q[j] <= PRW'($signed({1'b0, pix_i[j]})) * PRW'($signed(coef_i[j]));
      off_q  <= fmt_i ? (ACW'($signed(coef_i[3])) <<< FRAC_F1)
                      : (ACW'($signed(coef_i[3])) <<< FRAC_F0);
      byp1_q <= byp_i;
      fmt1_q <= fmt_i;
      bpx1_q <= byp_pix_i;
    end
  end

  // stage 2: accumulate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      byp2_q <= 1'b1;
      fmt2_q <= 1'b0;
      bpx2_q <= '0;
    end else begin
      acc_q  <= ACW'(prod_q[0]) + ACW'(prod_q[1]) + ACW'(prod_q[2]) + off_q;
      byp2_q <= byp1_q;
      fmt2_q <= fmt1_q;
      bpx2_q <= bpx1_q;
    end
  end

  // stage 3: round half-up, clamp
  logic signed [ACW-1:0] rnd;
  logic [PW-1:0]         sat;
  always_comb begin
    rnd = fmt2_q ? ((acc_q + HALF1) >>> FRAC_F1) : ((acc_q + HALF0) >>> FRAC_F0);
    if (rnd < 0)         sat = '0;
    else if (rnd > MAXV) sat = MAXV[PW-1:0];
    else                 sat = rnd[PW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= byp2_q ? bpx2_q : sat;
  end
endmodule

// File: rtl/gamut_remap_db.sv
module gamut_remap_db
  import cmx_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [4:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             frame_start_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_r_i,
  input  logic [PIX_W-1:0] pix_g_i,
  input  logic [PIX_W-1:0] pix_b_i,
  output logic             pix_valid_o,
  output logic [PIX_W-1:0] pix_r_o,
  output logic [PIX_W-1:0] pix_g_o,
  output logic [PIX_W-1:0] pix_b_o
);
  localparam int LAT = 3;

  mode_e                     mode_req, act_mode;
  logic                      act_fmt;
  logic [NCOEF-1:0][CW-1:0]  coef;
  logic [2:0][PIX_W-1:0]     pix_in, pix_out;
  logic [LAT-1:0]            vld_q;
  logic                      byp;

  cmx_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .frame_start_i(frame_start_i),
    .mode_req_o   (mode_req),
    .act_mode_o   (act_mode),
    .act_fmt_o    (act_fmt),
    .coef_o       (coef)
  );

  assign pix_in = {pix_b_i, pix_g_i, pix_r_i};
  assign byp    = (act_mode == MODE_BYP) || (act_mode == MODE_RSV);

  for (genvar r = 0; r < NROW; r++) begin : g_row
    cmx_row #(.PW(PIX_W)) u_row (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pix_i    (pix_in),
      .byp_pix_i(pix_in[r]),
      .coef_i   (coef[r*NCOL +: NCOL]),
      .fmt_i    (act_fmt),
      .byp_i    (byp),
      .pix_o    (pix_out[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], pix_valid_i};
  end

  assign pix_valid_o = vld_q[LAT-1];
  assign pix_r_o     = pix_out[0];
  assign pix_g_o     = pix_out[1];
  assign pix_b_o     = pix_out[2];
endmodule

// File: rtl/cmx_chk.sv
module cmx_chk #(
  parameter int PW = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_start_i,
  input logic            pix_valid_i,
  input logic [3*PW-1:0] pix_in,
  input logic            pix_valid_o,
  input logic [3*PW-1:0] pix_out,
  input logic [1:0]      act_mode,
  input logic [1:0]      mode_req
);
  logic [2:0] vsh;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vsh <= '0;
    else         vsh <= {vsh[1:0], pix_valid_i};
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> !pix_valid_o);

  // R3
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o == vsh[2]);

  // R6
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_mode));

  // R6
  mode_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> act_mode == $past(mode_req));

  // R2 R7
  bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && ($past(act_mode, 3) == 2'd0 || $past(act_mode, 3) == 2'd3))
      |-> pix_out == $past(pix_in, 3));
endmodule

bind gamut_remap_db cmx_chk #(.PW(PIX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .pix_valid_i  (pix_valid_i),
  .pix_in       ({pix_b_i, pix_g_i, pix_r_i}),
  .pix_valid_o  (pix_valid_o),
  .pix_out      ({pix_b_o, pix_g_o, pix_r_o}),
  .act_mode     (act_mode),
  .mode_req     (mode_req)
);

// File: tb/sim_gamut_remap_db.sv
module sim_gamut_remap_db;
  localparam int PW  = 10;
  localparam int MAX = (1 << PW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [4:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          frame_start_i = 1'b0;
  logic          pix_valid_i = 1'b0;
  logic [PW-1:0] pix_r_i = '0, pix_g_i = '0, pix_b_i = '0;
  logic          pix_valid_o;
  logic [PW-1:0] pix_r_o, pix_g_o, pix_b_o;

  always #2 clk_i = ~clk_i;

  gamut_remap_db #(.PIX_W(PW)) u0 (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int bank_m [2][12];
  int fmt_req = 0, fmt_act = 0, mode_req = 0, mode_act = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 5'(addr); reg_wdata_i = 32'(data);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int addr, output int v);
    @(negedge clk_i);
    reg_addr_i = 5'(addr);
    #1 v = int'(reg_rdata_o);
  endtask

  task automatic frame_pulse();
    @(negedge clk_i);
    frame_start_i = 1'b1;
    @(negedge clk_i);
    frame_start_i = 1'b0;
    mode_act = mode_req;
    fmt_act  = fmt_req;
  endtask

  task automatic set_mode(input int m);
    mode_req = m;
    wr(0, m);
  endtask

  task automatic set_fmt(input int f);
    fmt_req = f;
    wr(1, f);
  endtask

  task automatic set_row(input int b, input int row, input int c0, input int c1,
                         input int c2, input int c3);
    bank_m[b][row*4]   = c0;
    bank_m[b][row*4+1] = c1;
    bank_m[b][row*4+2] = c2;
    bank_m[b][row*4+3] = c3;
  endtask

  function automatic int pack_word(input int b, input int w);
    return ((bank_m[b][2*w+1] & 16'hffff) << 16) | (bank_m[b][2*w] & 16'hffff);
  endfunction

  task automatic flush_bank(input int b);
    for (int w = 0; w < 6; w++) wr((b == 0 ? 8 : 16) + w, pack_word(b, w));
  endtask

  function automatic int model(input int row, input int r, input int g, input int b);
    int px [3];
    int acc, f, v;
    px[0] = r; px[1] = g; px[2] = b;
    if (mode_act == 0 || mode_act == 3) return px[row];
    f = fmt_act ? 12 : 13;
    acc = 0;
    for (int j = 0; j < 3; j++) acc += bank_m[mode_act-1][row*4+j] * px[j];
    acc += bank_m[mode_act-1][row*4+3] <<< f;
    v = (acc + (1 << (f-1))) >>> f;
    if (v < 0) v = 0;
    if (v > MAX) v = MAX;
    return v;
  endfunction

  task automatic px(input string tag, input int r, input int g, input int b);
    int er, eg, eb;
    er = model(0, r, g, b); eg = model(1, r, g, b); eb = model(2, r, g, b);
    @(negedge clk_i);
    pix_valid_i = 1'b1; pix_r_i = PW'(r); pix_g_i = PW'(g); pix_b_i = PW'(b);
    @(negedge clk_i);
    pix_valid_i = 1'b0;
    @(negedge clk_i);
    chk({tag, " R3 valid early"}, int'(pix_valid_o), 0);
    @(negedge clk_i);
    chk({tag, " R3 valid"}, int'(pix_valid_o), 1);
    chk({tag, " red"},   int'(pix_r_o), er);
    chk({tag, " green"}, int'(pix_g_o), eg);
    chk({tag, " blue"},  int'(pix_b_o), eb);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 valid after reset", int'(pix_valid_o), 0);
    rd(0, v);
    chk("R1 ctrl after reset", v, 0);
  endtask

  task automatic t_bypass();
    px("R2 bypass a", 0, 512, 1023);
    px("R2 bypass b", 5, 6, 7);
  endtask

  task automatic t_bank_a();
    int v;
    set_row(0, 0, 0, 8192, 0, 3);
    set_row(0, 1, 8192, 0, 0, -2);
    set_row(0, 2, 4096, 4096, 0, 0);
    flush_bank(0);
    set_mode(1);
    rd(0, v);
    chk("R6 active unchanged before pulse", v, 'h01);
    px("R6 still bypass before pulse", 100, 200, 300);
    frame_pulse();
    rd(0, v);
    chk("R6 active after pulse", v, 'h11);
    px("R4 bank A", 100, 200, 300);
    px("R4 bank A second", 700, 50, 9);
    px("R9 clamp low", 0, 0, 0);
    px("R11 round half up", 1, 0, 9);
    px("R11 round 1.5", 1, 2, 0);
  endtask

  task automatic t_pack();
    int v;
    rd(9, v);
    chk("R10 word C13/C14", v, pack_word(0, 1));
    chk("R10 literal", v, 32'h0003_0000);
    rd(10, v);
    chk("R10 word C21/C22", v, 32'h0000_2000);
  endtask

  task automatic t_pingpong();
    int v;
    set_row(1, 0, 16384, 0, 0, 0);
    set_row(1, 1, 0, 0, -8192, 1023);
    set_row(1, 2, 0, 0, 0, 0);
    flush_bank(1);
    rd(16, v);
    chk("R10 bank B word 0", v, 32'h0000_4000);
    px("R8 idle bank write ignored", 100, 200, 300);
    set_mode(2);
    px("R8 mode written not committed", 100, 200, 300);
    frame_pulse();
    px("R8 bank B live", 100, 200, 24);
    px("R9 clamp high", 600, 0, 0);
  endtask

  task automatic t_format();
    int v;
    set_fmt(1);
    rd(1, v);
    chk("R5 format readback", v, 1);
    px("R5 format pending", 100, 0, 24);
    frame_pulse();
    px("R5 format S3.12", 100, 0, 24);
    px("R5 format S3.12 second", 255, 3, 0);
  endtask

  task automatic t_reserved();
    int v;
    set_mode(3);
    frame_pulse();
    rd(0, v);
    chk("R7 active reserved", v, 'h33);
    px("R7 reserved acts bypass", 17, 900, 33);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < 12; i++) bank_m[b][i] = 0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_bypass();
    t_bank_a();
    t_pack();
    t_pingpong();
    t_format();
    t_reserved();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule